// File: doc/BRIEF.md
# CAN Error Status Interrupt Unit

This block holds the error-status and interrupt-flag state of a CAN controller. The protocol engine supplies it with the fault-confinement state, transmit bit-mismatch codes, receive and transmit error strobes, a stop-mode indication and the raw bus level. From these the unit keeps three sticky flags: bus-off entry, error seen and wake-up detected. Each flag has an enable bit in a mask word, and any enabled flag drives a registered interrupt request.

Software reaches the unit through a small register port. `reg_sel_i` picks the status word (0) or the mask word (1), and read data always shows the selected word. A flag can be cleared only by a two-step handshake: a read strobe on the status word while the flag is 1 arms that flag, and a later status write with 0 in that bit clears it. Every write disarms all flags. This means a flag that is raised between a read and a write cannot be lost by accident.

Top module: `can_err_irq_unit`

## Requirements
- R1: After reset, all three flags, all mask bits, all arm bits, the stored bit-error code and `irq_o` are 0. The status word then reads as only the live fault field.
- R2: Status bits [5:4] always show the live fault-confinement input: 00 error active, 01 error passive, 10 or 11 bus off. Writes to these bits are ignored.
- R3: Status bit 0 (bus-off flag) sets on a clock where the fault input goes from 00 or 01 into 10 or 11. A move between 10 and 11, or staying in bus off, does not set it again.
- R4: Status bit 1 (error flag) sets on a clock where `rx_err_i` or `tx_err_i` is 1, or the bit-error input is 01 (sent dominant, read recessive) or 10 (sent recessive, read dominant). Status bits [7:6] keep the most recent 01 or 10 code. Code 11 is unused: it neither sets the flag nor changes bits [7:6].
- R5: The bus input passes through a two-flop synchronizer. Status bit 2 (wake flag) sets when the synchronized level goes from recessive (1) to dominant (0) on a clock where `stop_mode_i` is 1. The same edge outside stop mode has no effect.
- R6: A read strobe on the status word arms each flag that reads 1. A later status write with 0 in an armed flag's bit clears that flag. A write of 1, or a write of 0 to an unarmed flag, leaves the flag set. Any write, to either word, disarms all flags.
- R7: If a flag's set event falls on the same clock as its valid clear, the flag stays 1.
- R8: The mask word holds the enables in bits 0 (bus-off), 1 (error) and 2 (wake). Its other bits read 0. In the status word, only the flag bits respond to writes.
- R9: On each clock, `irq_o` takes the OR over all flags of (flag AND its mask bit), sampled at the previous clock. It therefore stays 0 while all mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_state_i | input | 2 | Fault-confinement state from the protocol engine |
| txbit_err_i | input | 2 | Transmit bit-mismatch code for this clock |
| rx_err_i | input | 1 | Receive error strobe |
| tx_err_i | input | 1 | Transmit error strobe |
| stop_mode_i | input | 1 | Controller is in low-power stop mode |
| bus_rx_i | input | 1 | Raw bus level, 1 = recessive |
| reg_sel_i | input | 1 | 0 selects the status word, 1 selects the mask word |
| reg_rd_i | input | 1 | Read strobe (arms flags on a status read) |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Selected word, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that read and write strobes never occur on the same clock. They also assume that the error strobes and bit-error codes last one clock per event. The stimulus drives each register access as a single-clock strobe and clears the event inputs on the following clock. The bus line and the fault state are changed only from the bench's negative-edge driver, so the synchronizer sees clean levels. Several sequences test the handshake in ways that should not clear a flag: a write with no prior read, a write of 1 after a read, and a set event that lands on the clearing write.

// File: rtl/can_eiu_pkg.sv
package can_eiu_pkg;
  localparam int FLAG_N   = 3;
  localparam int IDX_BOFF = 0;
  localparam int IDX_ERR  = 1;
  localparam int IDX_WAKE = 2;
  localparam int STAT_W   = 8;

  typedef enum logic [1:0] {
    BE_NONE     = 2'b00,
    BE_DOM_LOST = 2'b01,
    BE_REC_LOST = 2'b10,
    BE_UNUSED   = 2'b11
  } biterr_e;

  function automatic logic in_bus_off(input logic [1:0] fs);
    return fs[1];
  endfunction

  function automatic logic biterr_event(input logic [1:0] code);
    return (code == BE_DOM_LOST) || (code == BE_REC_LOST);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [FLAG_N-1:0] flags,
                                                    input logic [1:0] fs,
                                                    input logic [1:0] be);
    return {be, fs, 1'b0, flags};
  endfunction
endpackage

// File: rtl/eiu_bus_edge.sv
module eiu_bus_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= bus_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], bus_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R5
endmodule

// File: rtl/eiu_flag_cell.sv
module eiu_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_arm_i,
  input  logic wr_i,
  input  logic wr_zero_i,
  output logic flag_o
);
  logic flag_q;
  logic arm_q;
  logic clr_ok;

  assign clr_ok = wr_i & wr_zero_i & arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~clr_ok);
      if (wr_i)                   arm_q <= 1'b0;
      else if (rd_arm_i & flag_q) arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q); // R7
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q && wr_i && wr_zero_i)); // R6
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !arm_q); // R6
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_i)); // R3
endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
  import can_eiu_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       fault_state_i,
  input  logic [1:0]       txbit_err_i,
  input  logic             rx_err_i,
  input  logic             tx_err_i,
  input  logic             stop_mode_i,
  input  logic             bus_rx_i,
  input  logic             reg_sel_i,
  input  logic             reg_rd_i,
  input  logic             reg_wr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  logic [1:0]        prev_fs_q;
  logic [1:0]        be_q;
  logic [FLAG_N-1:0] mask_q;
  logic [FLAG_N-1:0] flags;
  logic [FLAG_N-1:0] set_vec;
  logic              irq_q;
  logic              bus_fall;
  logic              boff_entry;
  logic              err_event;
  logic              wake_event;
  logic              stat_rd;
  logic              stat_wr;

  eiu_bus_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_i (bus_rx_i),
    .fall_o(bus_fall)
  );

  assign boff_entry = ~in_bus_off(prev_fs_q) & in_bus_off(fault_state_i);
  assign err_event  = rx_err_i | tx_err_i | biterr_event(txbit_err_i);
  assign wake_event = bus_fall & stop_mode_i;
  assign stat_rd    = reg_rd_i & ~reg_sel_i;
  assign stat_wr    = reg_wr_i & ~reg_sel_i;

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_BOFF] = boff_entry;
    set_vec[IDX_ERR]  = err_event;
    set_vec[IDX_WAKE] = wake_event;
  end

  generate
    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      eiu_flag_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec[i]),
        .rd_arm_i (stat_rd),
        .wr_i     (reg_wr_i),
        .wr_zero_i(stat_wr & ~reg_wdata_i[i]),
        .flag_o   (flags[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_fs_q <= 2'b00;
      be_q      <= BE_NONE;
      mask_q    <= '0;
      irq_q     <= 1'b0;
    end else begin
      prev_fs_q <= fault_state_i;
      if (biterr_event(txbit_err_i)) be_q <= txbit_err_i;
      if (reg_wr_i && reg_sel_i)     mask_q <= reg_wdata_i[FLAG_N-1:0];
      irq_q <= |(flags & mask_q);
    end
  end

  assign reg_rdata_o = reg_sel_i ? REG_W'(mask_q)
                                 : REG_W'(pack_status(flags, fault_state_i, be_q));
  assign irq_o = irq_q;

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(mask_q != '0)); // R9
  AST_BE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !biterr_event(txbit_err_i) |=> $stable(be_q)); // R4
  AST_BOFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[IDX_BOFF]) |-> $past(fault_state_i[1])); // R3
  AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[IDX_WAKE]) |-> $past(stop_mode_i)); // R5
endmodule

// File: tb/sim_can_err_irq_unit.sv
module sim_can_err_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fault_state_i = 2'b00;
  logic [1:0]  txbit_err_i = 2'b00;
  logic        rx_err_i = 1'b0;
  logic        tx_err_i = 1'b0;
  logic        stop_mode_i = 1'b0;
  logic        bus_rx_i = 1'b1;
  logic        reg_sel_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        irq_o;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  string cur_req = "R1";

  bit [2:0] m_flag, m_mask, m_arm;
  bit [1:0] m_be, m_prevfs;
  bit       m_irq;
  bit       bq[$];

  always #2 clk = ~clk;

  can_err_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .fault_state_i(fault_state_i), .txbit_err_i(txbit_err_i),
    .rx_err_i(rx_err_i), .tx_err_i(tx_err_i), .stop_mode_i(stop_mode_i), .bus_rx_i(bus_rx_i),
    .reg_sel_i(reg_sel_i), .reg_rd_i(reg_rd_i), .reg_wr_i(reg_wr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  task automatic model_reset();
    m_flag = 0; m_mask = 0; m_arm = 0; m_be = 0; m_prevfs = 0; m_irq = 0;
    bq = {1'b1, 1'b1, 1'b1, 1'b1};
  endtask

  task automatic model_update();
    bit [2:0] set;
    bit [2:0] nflag;
    bit       code_ok;
    bq.push_front(bus_rx_i);
    code_ok = (txbit_err_i == 2'd1) || (txbit_err_i == 2'd2);
    set[0] = (m_prevfs < 2) && (fault_state_i >= 2);
    set[1] = rx_err_i || tx_err_i || code_ok;
    set[2] = bq[3] && !bq[2] && stop_mode_i;
    void'(bq.pop_back());
    m_irq = (m_flag & m_mask) != 0;
    for (int i = 0; i < 3; i++) begin
      bit clr;
      clr = reg_wr_i && !reg_sel_i && !reg_wdata_i[i] && m_arm[i];
      nflag[i] = set[i] || (m_flag[i] && !clr);
      if (reg_wr_i) m_arm[i] = 0;
      else if (reg_rd_i && !reg_sel_i && m_flag[i]) m_arm[i] = 1;
    end
    m_flag = nflag;
    if (reg_wr_i && reg_sel_i) m_mask = reg_wdata_i[2:0];
    if (code_ok) m_be = txbit_err_i;
    m_prevfs = fault_state_i;
  endtask

  task automatic check16(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] exp;
    exp = reg_sel_i ? {13'b0, m_mask} : {8'b0, m_be, fault_state_i, 1'b0, m_flag};
    check16(cur_req, reg_rdata_o, exp);
    check1(cur_req, "irq", irq_o, m_irq);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle();
    reg_rd_i = 0; reg_wr_i = 0; rx_err_i = 0; tx_err_i = 0; txbit_err_i = 0;
  endtask

  task automatic hold(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_read(bit sel);
    reg_sel_i = sel; reg_rd_i = 1; step(); idle();
  endtask

  task automatic do_write(bit sel, logic [15:0] d);
    reg_sel_i = sel; reg_wr_i = 1; reg_wdata_i = d; step(); idle();
  endtask

  task automatic bus_fall();
    bus_rx_i = 0; hold(4); bus_rx_i = 1; hold(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state on both words
    cur_req = "R1";
    reg_sel_i = 0; @(negedge clk); compare();
    check16("R1", reg_rdata_o, 16'h0000);
    reg_sel_i = 1; @(negedge clk); compare();
    check16("R1", reg_rdata_o, 16'h0000);
    reg_sel_i = 0; hold(2);

    // R2 live fault field
    cur_req = "R2";
    fault_state_i = 2'b01; hold(1);
    fault_state_i = 2'b00; hold(1);
    do_write(0, 16'hFFF8);
    check16("R2", reg_rdata_o & 16'h0030, 16'h0000);

    // R3 bus-off entry, re-entry within bus off does not set
    cur_req = "R3";
    fault_state_i = 2'b01; hold(2);
    fault_state_i = 2'b10; hold(1);
    check1("R3", "boff flag", reg_rdata_o[0], 1'b1);
    check16("R2", reg_rdata_o & 16'h0030, 16'h0020);
    do_read(0); do_write(0, 16'h0000);
    check1("R3", "boff cleared", reg_rdata_o[0], 1'b0);
    fault_state_i = 2'b11; hold(2);
    check1("R3", "boff no re-set", reg_rdata_o[0], 1'b0);
    fault_state_i = 2'b00; hold(1);
    fault_state_i = 2'b11; hold(1);
    check1("R3", "boff from active", reg_rdata_o[0], 1'b1);
    fault_state_i = 2'b00; do_read(0); do_write(0, 16'h0000);

    // R4 error sources and bit-error code latching
    cur_req = "R4";
    rx_err_i = 1; step(); idle(); hold(1);
    do_read(0); do_write(0, 16'h0000);
    tx_err_i = 1; step(); idle(); hold(1);
    do_read(0); do_write(0, 16'h0000);
    txbit_err_i = 2'b01; step(); idle();
    check16("R4", reg_rdata_o & 16'h00C2, 16'h0042);
    do_read(0); do_write(0, 16'h0000);
    txbit_err_i = 2'b11; step(); idle(); hold(1);
    check16("R4", reg_rdata_o & 16'h00C2, 16'h0040);
    txbit_err_i = 2'b10; step(); idle();
    check16("R4", reg_rdata_o & 16'h00C2, 16'h0082);
    do_read(0); do_write(0, 16'h0000);

    // R5 wake detection only in stop mode
    cur_req = "R5";
    stop_mode_i = 0; bus_fall();
    check1("R5", "wake outside stop", reg_rdata_o[2], 1'b0);
    stop_mode_i = 1; bus_fall();
    check1("R5", "wake in stop", reg_rdata_o[2], 1'b1);
    stop_mode_i = 0;

    // R6 handshake corner cases on the wake flag
    cur_req = "R6";
    do_write(0, 16'h0000);
    check1("R6", "write without read", reg_rdata_o[2], 1'b1);
    do_read(0); do_write(0, 16'h0004);
    check1("R6", "write of one", reg_rdata_o[2], 1'b1);
    do_write(0, 16'h0000);
    check1("R6", "disarmed by write", reg_rdata_o[2], 1'b1);
    do_read(0); do_write(1, 16'h0000); do_write(0, 16'h0000);
    check1("R6", "disarmed by mask write", reg_rdata_o[2], 1'b1);
    do_read(0); hold(2); do_write(0, 16'h0000);
    check1("R6", "armed clear", reg_rdata_o[2], 1'b0);

    // R7 set beats clear
    cur_req = "R7";
    rx_err_i = 1; step(); idle();
    do_read(0);
    reg_sel_i = 0; reg_wr_i = 1; reg_wdata_i = 16'h0000; rx_err_i = 1; step(); idle();
    check1("R7", "set wins", reg_rdata_o[1], 1'b1);
    do_read(0); do_write(0, 16'h0000);
    check1("R7", "later clear", reg_rdata_o[1], 1'b0);

    // R8 mask layout and write-ignored status fields
    cur_req = "R8";
    do_write(1, 16'hFFFF);
    reg_sel_i = 1; @(negedge clk); compare();
    check16("R8", reg_rdata_o, 16'h0007);
    do_write(1, 16'h0000);
    do_write(0, 16'hFFFF);
    check16("R8", reg_rdata_o & 16'hFFF8, 16'h0080);

    // R9 masked interrupt timing
    cur_req = "R9";
    rx_err_i = 1; step(); idle(); hold(2);
    check1("R9", "irq masked off", irq_o, 1'b0);
    do_write(1, 16'h0002);
    check1("R9", "irq one cycle after mask", irq_o, 1'b0);
    reg_sel_i = 0; hold(1);
    check1("R9", "irq raised", irq_o, 1'b1);
    do_write(1, 16'h0005); hold(1);
    check1("R9", "irq other masks", irq_o, 1'b0);
    do_write(1, 16'h0002);
    do_read(0); do_write(0, 16'h0000); hold(1);
    check1("R9", "irq drops after clear", irq_o, 1'b0);
    hold(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule